// File: doc/BRIEF.md
# Indexed Byte Store With Toggled Lock Windows

This block puts a byte-wide on-chip store behind a four-byte I/O window. The store is never addressed directly. Software first loads a 16-bit pointer one byte at a time through two pointer offsets. It then moves one data byte through a third offset. A data write stores the byte and sends the pointer back to zero. A data read returns the byte and leaves the pointer where it was. The remaining offset is a spare slot: writes to it do nothing and reads of it return all ones.

The block has a set of lock bits, two by default. Each lock bit guards a 16-byte window of the store. A lock bit is never written with a value. Each request on the toggle input, with a select value naming the bit, inverts that bit. While a window is locked, reads inside it return 0xFF and writes inside it are dropped without any report. Pointer values at or beyond the store size behave the same way. Reset clears the pointer and the lock bits and leaves the stored bytes as they are.

A small state machine produces the read response. It has three states:
- `ST_IDLE`: no response is due.
- `ST_RESP_DATA`: a permitted data read was accepted in the previous cycle, and the byte from the store is presented.
- `ST_RESP_ONES`: any other read was accepted in the previous cycle, and 0xFF is presented.

Every cycle the machine chooses its next state from the request on the port, whatever state it is in. These transitions are named:
- `GO_DATA`: a permitted data read moves the machine to `ST_RESP_DATA`.
- `GO_ONES`: a spare read, a locked read or an out-of-range read moves it to `ST_RESP_ONES`.
- `GO_IDLE`: a write, or no request, moves it to `ST_IDLE`.

Because the next state does not depend on the current one, a new request may be accepted in every cycle.

Top module: `nvram_index_port`

## Requirements
- R1: A write to offset 0 replaces bits 7:0 of the pointer and keeps bits 15:8. A write to offset 1 replaces bits 15:8 and keeps bits 7:0.
- R2: A write to offset 3 stores `io_wdata` at the pointer address when that address is permitted. The pointer then reads 0x0000 from the next cycle on, whether or not the byte was stored.
- R3: A read from offset 3 of a permitted address raises `io_rvalid` for exactly the cycle after the accepting clock edge, with the stored byte on `io_rdata` in that cycle. The pointer is left unchanged.
- R4: A read from offset 0, 1 or 2 returns 0xFF with `io_rvalid` in the next cycle. A write to offset 2 changes neither the pointer nor the store.
- R5: When lock bit i is set, the addresses 0x20+16·i through 0x2F+16·i are blocked. With the default two bits, bit 0 covers 0x20–0x2F and bit 1 covers 0x30–0x3F. A blocked read returns 0xFF. A blocked write leaves the stored byte unchanged.
- R6: A clock edge with `lock_tgl` high inverts the lock bit selected by `lock_sel` and leaves the other lock bits as they are. A lock bit is never loaded with a value.
- R7: When the pointer is at or beyond `MEM_BYTES`, a data read returns 0xFF and a data write changes no stored byte.
- R8: Reset clears the pointer to 0x0000 and clears every lock bit. It keeps the stored bytes.
- R9: `io_rvalid` is low in any cycle that does not follow an accepted read. Writes never produce a response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; everything changes on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| io_req | input | 1 | Access request on the I/O window, taken every cycle it is high |
| io_we | input | 1 | 1 = write, 0 = read |
| io_off | input | 2 | Offset: 0 = pointer low byte, 1 = pointer high byte, 2 = spare, 3 = data |
| io_wdata | input | 8 | Write byte |
| io_rdata | output | 8 | Read byte; valid while io_rvalid is high, 0xFF otherwise |
| io_rvalid | output | 1 | High in the cycle after an accepted read |
| lock_tgl | input | 1 | Toggle request for one lock bit |
| lock_sel | input | LSEL_W | Index of the lock bit to toggle |

## Verification
Pointer loads, data stores, pointer clearing and lock toggles all take effect at the edge that accepts them. Their results are first visible in the cycle after that edge. A read response is due in exactly that cycle too, since only the registered store output and the state register lie between the request and `io_rdata`. The bench drives every stimulus on a falling edge and samples the response on the next falling edge, so each check reads the cycle in which its result is due. The store is swept across all addresses, with expected bytes computed from an address formula. It is then read back under each of the four lock combinations and at addresses past the end of the store.

// File: rtl/nvip_pkg.sv
package nvip_pkg;

    localparam int PTR_W = 16;

    localparam logic [1:0] OFF_PTR_LO = 2'd0;
    localparam logic [1:0] OFF_PTR_HI = 2'd1;
    localparam logic [1:0] OFF_SPARE  = 2'd2;
    localparam logic [1:0] OFF_DATA   = 2'd3;

    localparam logic [7:0] BYTE_ONES  = 8'hFF;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_RESP_DATA = 2'd1,
        ST_RESP_ONES = 2'd2
    } nvip_state_e;

endpackage

// File: rtl/nvip_ptr.sv
module nvip_ptr
    import nvip_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_lo,
    input  logic             ld_hi,
    input  logic             clr,
    input  logic [7:0]       din,
    output logic [PTR_W-1:0] ptr
);

    logic [PTR_W-1:0] ptr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (clr) begin
            ptr_q <= '0;
        end else if (ld_lo) begin
            ptr_q[7:0] <= din;
        end else if (ld_hi) begin
            ptr_q[PTR_W-1:8] <= din;
        end
    end

    assign ptr = ptr_q;

endmodule

// File: rtl/nvip_lock.sv
module nvip_lock
    import nvip_pkg::*;
#(
    parameter int NUM_LOCKS = 2,
    parameter int WIN_BASE  = 32,
    parameter int WIN_SPAN  = 16,
    localparam int LSEL_W   = (NUM_LOCKS > 1) ? $clog2(NUM_LOCKS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tgl,
    input  logic [LSEL_W-1:0]    sel,
    input  logic [PTR_W-1:0]     addr,
    output logic [NUM_LOCKS-1:0] lock_bits,
    output logic                 blocked
);

    logic [NUM_LOCKS-1:0] lock_q;
    logic [NUM_LOCKS-1:0] hit;
    logic [31:0]          addr32;

    assign addr32 = 32'(addr);

    for (genvar i = 0; i < NUM_LOCKS; i++) begin : g_win
        localparam logic [31:0] LO = 32'(WIN_BASE + i * WIN_SPAN);
        localparam logic [31:0] HI = 32'(WIN_BASE + (i + 1) * WIN_SPAN);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lock_q[i] <= 1'b0;
            end else if (tgl && (sel == LSEL_W'(i))) begin
                lock_q[i] <= ~lock_q[i];
            end
        end

        assign hit[i] = lock_q[i] && (addr32 >= LO) && (addr32 < HI);
    end

    assign lock_bits = lock_q;
    assign blocked   = |hit;

endmodule

// File: rtl/nvip_mem.sv
module nvip_mem #(
    parameter int  MEM_BYTES = 256,
    localparam int IDX_W     = (MEM_BYTES > 1) ? $clog2(MEM_BYTES) : 1
) (
    input  logic             clk,
    input  logic             we,
    input  logic             re,
    input  logic [IDX_W-1:0] idx,
    input  logic [7:0]       wdata,
    output logic [7:0]       rdata
);

    logic [7:0] cells [MEM_BYTES];
    logic [7:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we) begin
            cells[idx] <= wdata;
        end
        if (re) begin
            rdata_q <= cells[idx];
        end
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/nvip_ctrl.sv
module nvip_ctrl
    import nvip_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       io_req,
    input  logic       io_we,
    input  logic [1:0] io_off,
    input  logic       blocked,
    input  logic       in_range,
    input  logic [7:0] mem_rdata,
    output logic       ptr_ld_lo,
    output logic       ptr_ld_hi,
    output logic       ptr_clr,
    output logic       mem_we,
    output logic       mem_re,
    output logic       io_rvalid,
    output logic [7:0] io_rdata
);

    nvip_state_e state_q, state_d;

    logic rd_req, wr_req, data_slot, permitted;

    assign rd_req    = io_req && !io_we;
    assign wr_req    = io_req && io_we;
    assign data_slot = (io_off == OFF_DATA);
    assign permitted = in_range && !blocked;

    // transition choice: GO_DATA, GO_ONES, GO_IDLE
    always_comb begin
        if (rd_req && data_slot && permitted) begin
            state_d = ST_RESP_DATA;
        end else if (rd_req) begin
            state_d = ST_RESP_ONES;
        end else begin
            state_d = ST_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // side-band strobes for the pointer and the store
    always_comb begin
        ptr_ld_lo = wr_req && (io_off == OFF_PTR_LO);
        ptr_ld_hi = wr_req && (io_off == OFF_PTR_HI);
        ptr_clr   = wr_req && data_slot;
        mem_we    = wr_req && data_slot && permitted;
        mem_re    = rd_req && data_slot && permitted;
    end

    // response outputs from the state
    always_comb begin
        unique case (state_q)
            ST_IDLE: begin
                io_rvalid = 1'b0;
                io_rdata  = BYTE_ONES;
            end
            ST_RESP_DATA: begin
                io_rvalid = 1'b1;
                io_rdata  = mem_rdata;
            end
            ST_RESP_ONES: begin
                io_rvalid = 1'b1;
                io_rdata  = BYTE_ONES;
            end
            default: begin
                io_rvalid = 1'b0;
                io_rdata  = BYTE_ONES;
            end
        endcase
    end

endmodule

// File: rtl/nvram_index_port.sv
module nvram_index_port
    import nvip_pkg::*;
#(
    parameter int  MEM_BYTES = 256,
    parameter int  NUM_LOCKS = 2,
    parameter int  WIN_BASE  = 32,
    parameter int  WIN_SPAN  = 16,
    localparam int LSEL_W    = (NUM_LOCKS > 1) ? $clog2(NUM_LOCKS) : 1,
    localparam int IDX_W     = (MEM_BYTES > 1) ? $clog2(MEM_BYTES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_req,
    input  logic              io_we,
    input  logic [1:0]        io_off,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    output logic              io_rvalid,
    input  logic              lock_tgl,
    input  logic [LSEL_W-1:0] lock_sel
);

    logic [PTR_W-1:0]     ptr_q;
    logic [NUM_LOCKS-1:0] lock_q;
    logic                 blocked;
    logic                 in_range;
    logic                 ptr_ld_lo, ptr_ld_hi, ptr_clr;
    logic                 mem_we, mem_re;
    logic [7:0]           mem_rdata;

    assign in_range = (32'(ptr_q) < 32'(MEM_BYTES));

    nvip_ptr u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .ld_lo (ptr_ld_lo),
        .ld_hi (ptr_ld_hi),
        .clr   (ptr_clr),
        .din   (io_wdata),
        .ptr   (ptr_q)
    );

    nvip_lock #(
        .NUM_LOCKS (NUM_LOCKS),
        .WIN_BASE  (WIN_BASE),
        .WIN_SPAN  (WIN_SPAN)
    ) u_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .tgl       (lock_tgl),
        .sel       (lock_sel),
        .addr      (ptr_q),
        .lock_bits (lock_q),
        .blocked   (blocked)
    );

    nvip_mem #(
        .MEM_BYTES (MEM_BYTES)
    ) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .re    (mem_re),
        .idx   (ptr_q[IDX_W-1:0]),
        .wdata (io_wdata),
        .rdata (mem_rdata)
    );

    nvip_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .io_req    (io_req),
        .io_we     (io_we),
        .io_off    (io_off),
        .blocked   (blocked),
        .in_range  (in_range),
        .mem_rdata (mem_rdata),
        .ptr_ld_lo (ptr_ld_lo),
        .ptr_ld_hi (ptr_ld_hi),
        .ptr_clr   (ptr_clr),
        .mem_we    (mem_we),
        .mem_re    (mem_re),
        .io_rvalid (io_rvalid),
        .io_rdata  (io_rdata)
    );

endmodule

// File: rtl/nvip_checker.sv
module nvip_checker
    import nvip_pkg::*;
#(
    parameter int  NUM_LOCKS = 2,
    localparam int LSEL_W    = (NUM_LOCKS > 1) ? $clog2(NUM_LOCKS) : 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 io_req,
    input logic                 io_we,
    input logic [1:0]           io_off,
    input logic [7:0]           io_wdata,
    input logic [7:0]           io_rdata,
    input logic                 io_rvalid,
    input logic                 lock_tgl,
    input logic [LSEL_W-1:0]    lock_sel,
    input logic [PTR_W-1:0]     ptr_q,
    input logic [NUM_LOCKS-1:0] lock_q,
    input logic                 blocked,
    input logic                 in_range
);

    p_ptr_lo_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        io_req && io_we && io_off == OFF_PTR_LO |=>
            ptr_q[7:0] == $past(io_wdata) && ptr_q[15:8] == $past(ptr_q[15:8]));

    p_ptr_hi_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        io_req && io_we && io_off == OFF_PTR_HI |=>
            ptr_q[15:8] == $past(io_wdata) && ptr_q[7:0] == $past(ptr_q[7:0]));

    p_ptr_clear_on_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
        io_req && io_we && io_off == OFF_DATA |=> ptr_q == '0);

    p_read_response_r3: assert property (@(posedge clk) disable iff (!rst_n)
        io_req && !io_we |=> io_rvalid);

    p_read_keeps_ptr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        io_req && !io_we |=> $stable(ptr_q));

    p_spare_read_ones_r4: assert property (@(posedge clk) disable iff (!rst_n)
        io_req && !io_we && io_off != OFF_DATA |=> io_rdata == 8'hFF);

    p_spare_write_keeps_ptr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        io_req && io_we && io_off == OFF_SPARE |=> $stable(ptr_q));

    p_locked_read_ones_r5: assert property (@(posedge clk) disable iff (!rst_n)
        io_req && !io_we && io_off == OFF_DATA && blocked |=> io_rdata == 8'hFF);

    p_toggle_flips_r6: assert property (@(posedge clk) disable iff (!rst_n)
        lock_tgl && 32'(lock_sel) < 32'(NUM_LOCKS) |=>
            $countones(lock_q ^ $past(lock_q)) == 1);

    p_no_toggle_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_tgl |=> $stable(lock_q));

    p_out_of_range_ones_r7: assert property (@(posedge clk) disable iff (!rst_n)
        io_req && !io_we && io_off == OFF_DATA && !in_range |=> io_rdata == 8'hFF);

    p_no_stray_rvalid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_req && !io_we) |=> !io_rvalid);

endmodule

bind nvram_index_port nvip_checker #(
    .NUM_LOCKS (NUM_LOCKS)
) u_nvip_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .io_req    (io_req),
    .io_we     (io_we),
    .io_off    (io_off),
    .io_wdata  (io_wdata),
    .io_rdata  (io_rdata),
    .io_rvalid (io_rvalid),
    .lock_tgl  (lock_tgl),
    .lock_sel  (lock_sel),
    .ptr_q     (ptr_q),
    .lock_q    (lock_q),
    .blocked   (blocked),
    .in_range  (in_range)
);

// File: tb/nvram_index_port_bench.sv
module nvram_index_port_bench;

    localparam int MEMB = 256;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       io_req = 1'b0;
    logic       io_we = 1'b0;
    logic [1:0] io_off = 2'd0;
    logic [7:0] io_wdata = 8'd0;
    logic [7:0] io_rdata;
    logic       io_rvalid;
    logic       lock_tgl = 1'b0;
    logic [0:0] lock_sel = 1'b0;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    nvram_index_port #(.MEM_BYTES(MEMB)) u_nvram_index_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .io_req    (io_req),
        .io_we     (io_we),
        .io_off    (io_off),
        .io_wdata  (io_wdata),
        .io_rdata  (io_rdata),
        .io_rvalid (io_rvalid),
        .lock_tgl  (lock_tgl),
        .lock_sel  (lock_sel)
    );

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 37 + 11) & 255);
    endfunction

    task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // all tasks start and end on a falling edge
    task automatic wr(input logic [1:0] off, input logic [7:0] d);
        io_req = 1'b1; io_we = 1'b1; io_off = off; io_wdata = d;
        @(negedge clk);
        io_req = 1'b0; io_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] off, output logic [8:0] r);
        io_req = 1'b1; io_we = 1'b0; io_off = off;
        @(negedge clk);
        io_req = 1'b0;
        r = {io_rvalid, io_rdata};
    endtask

    task automatic set_ptr(input logic [15:0] p);
        wr(2'd0, p[7:0]);
        wr(2'd1, p[15:8]);
    endtask

    task automatic toggle(input logic s);
        lock_tgl = 1'b1; lock_sel = s;
        @(negedge clk);
        lock_tgl = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual expired expected finish");
        finish_run();
    end

    initial begin
        logic [8:0] r;
        logic [1:0] lk;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R9 reset idle", {8'h0, io_rvalid}, 9'h0);

        // fill the whole store with the address pattern
        for (int a = 0; a < MEMB; a++) begin
            set_ptr(16'(a));
            wr(2'd3, pat(a));
        end

        // R3: read back all addresses, locks open
        for (int a = 0; a < MEMB; a++) begin
            set_ptr(16'(a));
            rd(2'd3, r);
            check("R3 sweep", r, {1'b1, pat(a)});
        end

        // R5, R6: lock combinations over the window area
        lk = 2'b00;
        for (int c = 1; c < 4; c++) begin
            if (c[0] != lk[0]) toggle(1'b0);
            if (c[1] != lk[1]) toggle(1'b1);
            lk = 2'(c);
            for (int a = 16; a < 80; a++) begin
                logic blk;
                blk = (a >= 32 && a < 48 && lk[0]) || (a >= 48 && a < 64 && lk[1]);
                set_ptr(16'(a));
                rd(2'd3, r);
                check(blk ? "R5 locked read" : "R6 open read", r,
                      {1'b1, blk ? 8'hFF : pat(a)});
            end
        end
        // both locked: writes into windows must be dropped
        for (int a = 32; a < 64; a++) begin
            set_ptr(16'(a));
            wr(2'd3, 8'h5A);
        end
        toggle(1'b0);
        toggle(1'b1);
        for (int a = 32; a < 64; a++) begin
            set_ptr(16'(a));
            rd(2'd3, r);
            check("R5 locked write dropped", r, {1'b1, pat(a)});
        end
        // R6: a double toggle is a no-op
        toggle(1'b0);
        toggle(1'b0);
        set_ptr(16'h0025);
        rd(2'd3, r);
        check("R6 double toggle", r, {1'b1, pat(37)});

        // R1: each pointer byte loads alone
        set_ptr(16'h0040);
        wr(2'd0, 8'h07);
        rd(2'd3, r);
        check("R1 low byte only", r, {1'b1, pat(7)});
        wr(2'd1, 8'h00);
        wr(2'd0, 8'h11);
        wr(2'd1, 8'h00);
        rd(2'd3, r);
        check("R1 high keeps low", r, {1'b1, pat(17)});

        // R3: pointer is kept across reads
        rd(2'd3, r);
        check("R3 second read same ptr", r, {1'b1, pat(17)});

        // R2: pointer clears after data write
        set_ptr(16'h0045);
        wr(2'd3, 8'hA5);
        check("R9 no rvalid after write", {8'h0, io_rvalid}, 9'h0);
        rd(2'd3, r);
        check("R2 ptr cleared", r, {1'b1, pat(0)});
        set_ptr(16'h0045);
        rd(2'd3, r);
        check("R2 byte stored", r, {1'b1, 8'hA5});
        set_ptr(16'h0045);
        wr(2'd3, pat(69));

        // R4: spare offsets
        for (int o = 0; o < 3; o++) begin
            rd(2'(o), r);
            check("R4 spare read", r, 9'h1FF);
        end
        set_ptr(16'h0012);
        wr(2'd2, 8'h99);
        rd(2'd3, r);
        check("R4 spare write ignored", r, {1'b1, pat(18)});

        // R7: beyond the store
        set_ptr(16'h0100);
        wr(2'd3, 8'h3C);
        rd(2'd3, r);
        check("R2 ptr cleared after ignored write", r, {1'b1, pat(0)});
        foreach (r[i]) begin end
        for (int k = 0; k < 3; k++) begin
            logic [15:0] p;
            p = (k == 0) ? 16'h0100 : (k == 1) ? 16'h01FF : 16'hFFFF;
            set_ptr(p);
            rd(2'd3, r);
            check("R7 out of range read", r, 9'h1FF);
        end
        set_ptr(16'h0000);
        rd(2'd3, r);
        check("R7 no alias write", r, {1'b1, pat(0)});

        // R9: idle cycle after a read drops rvalid
        @(negedge clk);
        check("R9 idle", {8'h0, io_rvalid}, 9'h0);

        // R8: reset keeps memory, clears pointer and locks
        toggle(1'b0);
        set_ptr(16'h0025);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd(2'd3, r);
        check("R8 ptr cleared", r, {1'b1, pat(0)});
        set_ptr(16'h0025);
        rd(2'd3, r);
        check("R8 lock cleared mem kept", r, {1'b1, pat(37)});

        finish_run();
    end

endmodule